// File: doc/BRIEF.md
# I2C Master Register and Interrupt Unit

This block is the host-facing register file of a byte-oriented I2C master. A host reaches it over a simple synchronous bus in which every register has its own 32-bit word offset. Reads are registered, so the read value appears one cycle after the read strobe. The unit holds the control word, the target address, a timeout value and a live transfer-size counter. It also holds one data FIFO that both directions share. In a write transfer the host pushes bytes into it and the bus engine drains them. In a read transfer the engine fills it and the host pops bytes out through the data register.

Events from the bus engine arrive as single-cycle pulses. The unit also raises three events of its own, for FIFO misuse. All of them are latched into a sticky event register that the host clears by writing ones. The host never writes the interrupt mask directly. It writes ones to an enable register to unmask events and ones to a disable register to mask them again. The unit drives a single interrupt line, which is high whenever an event is latched and not masked.

Top module: `i2c_regblk`

## Requirements
- R1: After reset, the registers read as follows: control 0, status 0, event register 0, transfer size 0, mask 0x3FF (all masked), timeout 0xFF. The interrupt line is low.
- R2: Each register sits at its own word offset: control 0, status 1, address 2, data 3, events 4, transfer size 5, pause 6, timeout 7, mask 8, enable 9, disable 10. Control keeps bits 15:0, address keeps bits 9:0 and timeout keeps bits 7:0. Offset 6 always reads 0. Every register reads back one cycle after the read strobe.
- R3: Bytes leave the shared FIFO in the order they entered it. A write to offset 3 pushes a byte, and an engine pop takes the head byte. An engine push adds a byte, and a read of offset 3 returns and removes the head byte.
- R4: The FIFO holds 16 bytes. A host push while the FIFO is full is dropped and sets event bit 6. An engine push while the FIFO is full is dropped and sets event bit 5.
- R5: A read of offset 3 while the FIFO is empty returns 0 and sets event bit 7.
- R6: An event input pulse latches the matching bit of the event register. Writing ones to offset 4 clears only those bits. A set and a clear of the same bit in the same cycle leaves the bit set. Bit 8 is reserved and never sets.
- R7: Writing ones to offset 9 clears the matching mask bits, and writing ones to offset 10 sets them. A write to offset 8 has no effect.
- R8: The interrupt line equals the OR of the latched event bits whose mask bit is 0.
- R9: Writing control bit 6 empties the FIFO on the next clock edge. The bit reads as 1 for exactly one cycle and then clears itself.
- R10: The transfer-size register keeps the low 8 bits of a host write. It decreases by one on each engine decrement pulse and stays at 0 once it reaches 0.
- R11: Status bit 8 follows the engine's bus-active input. Status bit 7 mirrors event bit 5. With the FIFO not empty, status bit 5 is set when control bit 0 is 1 (read direction) and status bit 6 is set when control bit 0 is 0 (write direction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Host write strobe |
| req_rd | input | 1 | Host read strobe |
| req_addr | input | 4 | Register word offset |
| req_wdata | input | 32 | Host write data |
| rsp_rdata | output | 32 | Registered read data |
| evt_in | input | 10 | Event pulses from the bus engine |
| eng_busy | input | 1 | Bus engine reports the bus active |
| eng_tx_pop | input | 1 | Engine takes the FIFO head byte |
| tx_byte | output | 8 | Current FIFO head byte |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_xfer_dec | input | 1 | Engine decrements the transfer size |
| fifo_cnt | output | 5 | FIFO fill level |
| xfer_left | output | 8 | Current transfer size |
| ctrl_o | output | 16 | Control word |
| slv_addr | output | 10 | Target address |
| tmo_val | output | 8 | Timeout value |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions watch several rules on every cycle: the FIFO never exceeds its depth, and a flush always leaves it empty. A latched event survives any clear issued in the same cycle, and reserved bit 8 stays 0. Enable and disable writes change exactly the mask bits they name. The flush bit clears itself, and the transfer size never wraps below 0.

Some behaviour only the bench's scenarios can show. These are the byte ordering through the shared FIFO in both directions and the exact read values at each offset. They also cover the overflow and underflow flags raised at the full and empty boundaries, and the interrupt line following each mask change. The bench's reference model shadows every output on every clock.

// File: rtl/i2c_regblk_pkg.sv
// Package: register offsets, event bit positions and control/status bit
// positions shared by the register unit and its submodules.
package i2c_regblk_pkg;
    localparam int OFS_W  = 4;
    localparam int BUS_W  = 32;
    localparam int EV_W   = 10;
    localparam int CTRL_W = 16;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 4'd0,
        OFS_STAT  = 4'd1,
        OFS_ADDR  = 4'd2,
        OFS_DATA  = 4'd3,
        OFS_EVT   = 4'd4,
        OFS_XFER  = 4'd5,
        OFS_PAUSE = 4'd6,
        OFS_TMO   = 4'd7,
        OFS_MASK  = 4'd8,
        OFS_UNMSK = 4'd9,
        OFS_DOMSK = 4'd10
    } reg_ofs_e;

    // event register bit positions
    localparam int EV_RXOVF = 5;
    localparam int EV_TXOVF = 6;
    localparam int EV_RXUNF = 7;
    localparam int EV_RSVD  = 8;

    // control and status bit positions
    localparam int CT_DIR   = 0;
    localparam int CT_FLUSH = 6;
    localparam int ST_RXDV  = 5;
    localparam int ST_TXDV  = 6;
    localparam int ST_RXOVF = 7;
    localparam int ST_BUSY  = 8;
endpackage

// File: rtl/i2c_regblk_fifo.sv
// Module: i2c_regblk_fifo
// Shared byte FIFO with one push port, one pop port and a synchronous flush.
// Assumes: a push while full and a pop while empty are dropped; flush wins
// over push and pop; DEPTH is at least 2.
module i2c_regblk_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed byte.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Maintain pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R9
endmodule

// File: rtl/i2c_regblk_irq.sv
// Module: i2c_regblk_irq
// Sticky event register (write-one-to-clear, set wins), a mask driven by
// separate unmask/mask strobes, and the combined interrupt line.
// Assumes: unmask and mask strobes never occur in the same cycle.
module i2c_regblk_irq #(
    parameter int EV_W = 10,
    parameter int RSVD_BIT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] set_vec,
    input  logic            clr_wr,
    input  logic            unmask_wr,
    input  logic            mask_wr,
    input  logic [EV_W-1:0] wbits,
    output logic [EV_W-1:0] evt_q,
    output logic [EV_W-1:0] mask_q,
    output logic            irq
);
    localparam logic [EV_W-1:0] VALID = ~(EV_W'(1) << RSVD_BIT);

    logic [EV_W-1:0] set_eff, clr_eff;

    assign set_eff = set_vec & VALID;
    assign clr_eff = clr_wr ? wbits : '0;
    assign irq     = |(evt_q & ~mask_q);

    // Latch events; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_eff) | set_eff;
    end

    // Update the mask from the unmask and mask strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (unmask_wr) mask_q <= mask_q & ~wbits;
        else if (mask_wr)   mask_q <= mask_q | wbits;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_eff != '0) |=> ((evt_q & $past(set_eff)) == $past(set_eff))); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_q[RSVD_BIT]); // R6
    AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_wr |=> ((mask_q & $past(wbits)) == '0)); // R7
    AST_DOMASK: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> ((mask_q & $past(wbits)) == $past(wbits))); // R7
endmodule

// File: rtl/i2c_regblk.sv
// Module: i2c_regblk
// Host register file of a byte-oriented I2C master. It decodes the word-offset
// bus, routes host and engine traffic into the shared FIFO, raises FIFO misuse
// events, and keeps control, address, timeout and transfer-size registers.
// Assumes: req_wr and req_rd are never high together; at most one of host push
// and engine push is meaningful in a cycle (host push takes the port).
module i2c_regblk
    import i2c_regblk_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_W = 8,
    parameter int XFER_W = 8,
    parameter int ADDR_W = 10,
    parameter int TMO_W = 8,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [OFS_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic [BUS_W-1:0]  rsp_rdata,
    input  logic [EV_W-1:0]   evt_in,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_xfer_dec,
    output logic [CW-1:0]     fifo_cnt,
    output logic [XFER_W-1:0] xfer_left,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] slv_addr,
    output logic [TMO_W-1:0]  tmo_val,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [XFER_W-1:0] xfer_q;
    logic [BUS_W-1:0]  rdata_q, rd_mux;
    logic [EV_W-1:0]   evt_q, mask_q, set_vec;
    logic              ctrl_wr, xfer_wr, host_push, host_pop;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [BUS_W-1:0]  status;
    logic              unused_wbits;

    assign unused_wbits = &{1'b0, req_wdata[BUS_W-1:CTRL_W]};

    assign ctrl_wr   = req_wr && (req_addr == OFS_CTRL);
    assign xfer_wr   = req_wr && (req_addr == OFS_XFER);
    assign host_push = req_wr && (req_addr == OFS_DATA);
    assign host_pop  = req_rd && !req_wr && (req_addr == OFS_DATA);

    i2c_regblk_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ctrl_q[CT_FLUSH]),
        .push      (host_push || eng_rx_push),
        .push_data (host_push ? req_wdata[DATA_W-1:0] : eng_rx_data),
        .pop       (host_pop || eng_tx_pop),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    // Merge engine events with the FIFO misuse events raised here.
    always_comb begin
        set_vec = evt_in;
        if (host_push && fifo_full)                 set_vec[EV_TXOVF] = 1'b1;
        if (!host_push && eng_rx_push && fifo_full) set_vec[EV_RXOVF] = 1'b1;
        if (host_pop && fifo_empty)                 set_vec[EV_RXUNF] = 1'b1;
    end

    i2c_regblk_irq #(.EV_W(EV_W), .RSVD_BIT(EV_RSVD)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_wr    (req_wr && (req_addr == OFS_EVT)),
        .unmask_wr (req_wr && (req_addr == OFS_UNMSK)),
        .mask_wr   (req_wr && (req_addr == OFS_DOMSK)),
        .wbits     (req_wdata[EV_W-1:0]),
        .evt_q     (evt_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    // Assemble the live status word.
    always_comb begin
        status = '0;
        status[ST_RXDV]  = !fifo_empty && ctrl_q[CT_DIR];
        status[ST_TXDV]  = !fifo_empty && !ctrl_q[CT_DIR];
        status[ST_RXOVF] = evt_q[EV_RXOVF];
        status[ST_BUSY]  = eng_busy;
    end

    // Select the register addressed by a read.
    always_comb begin
        case (req_addr)
            OFS_CTRL: rd_mux = BUS_W'(ctrl_q);
            OFS_STAT: rd_mux = status;
            OFS_ADDR: rd_mux = BUS_W'(addr_q);
            OFS_DATA: rd_mux = fifo_empty ? '0 : BUS_W'(fifo_head);
            OFS_EVT:  rd_mux = BUS_W'(evt_q);
            OFS_XFER: rd_mux = BUS_W'(xfer_q);
            OFS_TMO:  rd_mux = BUS_W'(tmo_q);
            OFS_MASK: rd_mux = BUS_W'(mask_q);
            default:  rd_mux = '0;
        endcase
    end

    // Register read data for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (req_rd) rdata_q <= rd_mux;
    end

    // Control word; the flush bit clears itself after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= req_wdata[CTRL_W-1:0];
        else              ctrl_q[CT_FLUSH] <= 1'b0;
    end

    // Target address and timeout registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tmo_q  <= '1;
        end else if (req_wr) begin
            if (req_addr == OFS_ADDR) addr_q <= req_wdata[ADDR_W-1:0];
            if (req_addr == OFS_TMO)  tmo_q  <= req_wdata[TMO_W-1:0];
        end
    end

    // Transfer size: host load, engine decrement with a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                          xfer_q <= '0;
        else if (xfer_wr)                    xfer_q <= req_wdata[XFER_W-1:0];
        else if (eng_xfer_dec && xfer_q != 0) xfer_q <= xfer_q - 1'b1;
    end

    assign rsp_rdata = rdata_q;
    assign tx_byte   = fifo_head;
    assign xfer_left = xfer_q;
    assign ctrl_o    = ctrl_q;
    assign slv_addr  = addr_q;
    assign tmo_val   = tmo_q;

    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CT_FLUSH] && !ctrl_wr) |=> !ctrl_q[CT_FLUSH]); // R9
    AST_XFER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_dec && !xfer_wr && xfer_q == 0) |=> (xfer_q == 0)); // R10
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && fifo_empty) |=> evt_q[EV_RXUNF]); // R5
endmodule

// File: tb/sim_i2c_regblk.sv
// Bench for i2c_regblk: a behavioural reference model (queue based) is
// updated at every rising edge and compared with the outputs at each falling
// edge; directed scenarios add explicit checks per requirement.
module sim_i2c_regblk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 0, req_rd = 0;
    logic [3:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic [31:0] rsp_rdata;
    logic [9:0]  evt_in = 0;
    logic        eng_busy = 0, eng_tx_pop = 0, eng_rx_push = 0, eng_xfer_dec = 0;
    logic [7:0]  eng_rx_data = 0;
    logic [7:0]  tx_byte, xfer_left, tmo_val;
    logic [4:0]  fifo_cnt;
    logic [15:0] ctrl_o;
    logic [9:0]  slv_addr;
    logic        irq;

    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    i2c_regblk u0 (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .evt_in(evt_in), .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop),
        .tx_byte(tx_byte), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_xfer_dec(eng_xfer_dec), .fifo_cnt(fifo_cnt), .xfer_left(xfer_left),
        .ctrl_o(ctrl_o), .slv_addr(slv_addr), .tmo_val(tmo_val), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    byte unsigned mq[$];
    logic [15:0] m_ctrl;
    logic [9:0]  m_evt, m_mask, m_addr;
    logic [7:0]  m_xfer, m_tmo;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] s;
        s = 0;
        s[5] = (mq.size() != 0) && m_ctrl[0];
        s[6] = (mq.size() != 0) && !m_ctrl[0];
        s[7] = m_evt[5];
        s[8] = eng_busy;
        case (a)
            0: return {16'h0, m_ctrl};
            1: return s;
            2: return {22'h0, m_addr};
            3: return (mq.size() == 0) ? 32'h0 : {24'h0, mq[0]};
            4: return {22'h0, m_evt};
            5: return {24'h0, m_xfer};
            7: return {24'h0, m_tmo};
            8: return {22'h0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ctrl = 0; m_evt = 0; m_mask = 10'h3FF; m_addr = 0;
            m_xfer = 0; m_tmo = 8'hFF; m_rdata = 0;
        end else begin
            int n;
            bit hp, hr;
            logic [9:0] setv, clr;
            n  = mq.size();
            hp = req_wr && req_addr == 3;
            hr = req_rd && !req_wr && req_addr == 3;
            if (req_rd) m_rdata = m_read(req_addr);
            setv = evt_in & 10'h2FF;
            if (hp && n == 16) setv[6] = 1;
            if (!hp && eng_rx_push && n == 16) setv[5] = 1;
            if (hr && n == 0) setv[7] = 1;
            clr = (req_wr && req_addr == 4) ? req_wdata[9:0] : 10'h0;
            m_evt = (m_evt & ~clr) | setv;
            if (req_wr && req_addr == 9)  m_mask = m_mask & ~req_wdata[9:0];
            if (req_wr && req_addr == 10) m_mask = m_mask | req_wdata[9:0];
            if (m_ctrl[6]) mq.delete();
            else begin
                if ((hr || eng_tx_pop) && n != 0) void'(mq.pop_front());
                if ((hp || eng_rx_push) && n != 16)
                    mq.push_back(hp ? req_wdata[7:0] : eng_rx_data);
            end
            if (req_wr && req_addr == 0) m_ctrl = req_wdata[15:0];
            else m_ctrl[6] = 0;
            if (req_wr && req_addr == 2) m_addr = req_wdata[9:0];
            if (req_wr && req_addr == 7) m_tmo = req_wdata[7:0];
            if (req_wr && req_addr == 5) m_xfer = req_wdata[7:0];
            else if (eng_xfer_dec && m_xfer != 0) m_xfer = m_xfer - 1;
        end
    end

    // Compare every output with the model once per clock.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq vs model", {31'h0, irq}, {31'h0, |(m_evt & ~m_mask)});
            chk("R3 fill level vs model", {27'h0, fifo_cnt}, mq.size());
            if (mq.size() != 0) chk("R3 head byte vs model", {24'h0, tx_byte}, {24'h0, mq[0]});
            chk("R10 transfer size vs model", {24'h0, xfer_left}, {24'h0, m_xfer});
            chk("R9 control vs model", {16'h0, ctrl_o}, {16'h0, m_ctrl});
            chk("R2 address vs model", {22'h0, slv_addr}, {22'h0, m_addr});
            chk("R2 read data vs model", rsp_rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers (start and end at a falling edge) ----
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        req_wr = 1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        req_rd = 1; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_rd = 0;
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic pulse_evt(input logic [9:0] e);
        evt_in = e;
        @(posedge clk); @(negedge clk);
        evt_in = 0;
    endtask

    task automatic eng_pop();
        eng_tx_pop = 1;
        @(posedge clk); @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_push = 1; eng_rx_data = b;
        @(posedge clk); @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic eng_dec();
        eng_xfer_dec = 1;
        @(posedge clk); @(negedge clk);
        eng_xfer_dec = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        chk("R1 irq low after reset", {31'h0, irq}, 0);
        rd(0, 32'h0, "R1 control reset");
        rd(1, 32'h0, "R1 status reset");
        rd(4, 32'h0, "R1 events reset");
        rd(8, 32'h3FF, "R1 mask reset");
        rd(5, 32'h0, "R1 transfer size reset");
        rd(7, 32'hFF, "R1 timeout reset");

        // R2 offsets and field widths
        wr(0, 32'hFFFF_FFBF); rd(0, 32'hFFBF, "R2 control readback");
        wr(2, 32'hFFFF_F2A5); rd(2, 32'h2A5, "R2 address readback");
        wr(7, 32'h1234_565A); rd(7, 32'h5A, "R2 timeout readback");
        wr(6, 32'hFFFF_FFFF); rd(6, 32'h0, "R2 pause offset reads zero");
        wr(0, 32'h0);

        // R3 / R11 transmit direction
        wr(3, 32'h11); wr(3, 32'h22); wr(3, 32'h33);
        rd(1, 32'h40, "R11 transmit pending status");
        chk("R3 first byte at head", {24'h0, tx_byte}, 32'h11);
        eng_pop();
        chk("R3 second byte at head", {24'h0, tx_byte}, 32'h22);
        eng_pop(); eng_pop();
        chk("R3 drained", {27'h0, fifo_cnt}, 0);
        // R3 / R11 receive direction
        wr(0, 32'h1);
        eng_push(8'hA1); eng_push(8'hB2);
        rd(1, 32'h20, "R11 receive valid status");
        rd(3, 32'hA1, "R3 first received byte");
        rd(3, 32'hB2, "R3 second received byte");
        rd(1, 32'h0, "R11 status idle when empty");

        // R4 full boundary
        wr(0, 32'h0);
        for (int i = 0; i < 16; i++) wr(3, 32'h30 + i);
        chk("R4 sixteen stored", {27'h0, fifo_cnt}, 16);
        rd(4, 32'h0, "R4 no overflow at exactly full");
        wr(3, 32'hEE);
        rd(4, 32'h40, "R4 host overflow flag");
        chk("R4 level unchanged", {27'h0, fifo_cnt}, 16);
        chk("R4 head unchanged", {24'h0, tx_byte}, 32'h30);
        eng_push(8'h77);
        rd(4, 32'h60, "R4 engine overflow flag");
        rd(1, 32'hC0, "R11 overflow mirror in status");
        wr(4, 32'h40);
        rd(4, 32'h20, "R6 partial clear");

        // R9 flush
        wr(0, 32'h40);
        chk("R9 flush bit visible one cycle", {16'h0, ctrl_o}, 32'h40);
        @(posedge clk); @(negedge clk);
        chk("R9 FIFO empty after flush", {27'h0, fifo_cnt}, 0);
        chk("R9 flush bit self-cleared", {16'h0, ctrl_o}, 32'h0);

        // R5 underflow
        wr(4, 32'h3FF);
        rd(3, 32'h0, "R5 empty read returns zero");
        rd(4, 32'h80, "R5 underflow flag");

        // R6 events
        wr(4, 32'h3FF);
        pulse_evt(10'h10F);
        rd(4, 32'h00F, "R6 events latched, reserved ignored");
        wr(4, 32'h005);
        rd(4, 32'h00A, "R6 clear only written ones");
        evt_in = 10'h002; req_wr = 1; req_addr = 4; req_wdata = 32'h002;
        @(posedge clk); @(negedge clk);
        evt_in = 0; req_wr = 0;
        rd(4, 32'h00A, "R6 set wins over clear");
        pulse_evt(10'h200);
        rd(4, 32'h20A, "R6 arbitration bit latched");

        // R7 / R8 mask and interrupt
        chk("R8 irq low when all masked", {31'h0, irq}, 0);
        wr(9, 32'h002);
        rd(8, 32'h3FD, "R7 unmask clears bit");
        chk("R8 irq high on unmasked event", {31'h0, irq}, 1);
        wr(8, 32'h0);
        rd(8, 32'h3FD, "R7 mask write ignored");
        wr(4, 32'h002);
        chk("R8 irq low after clear", {31'h0, irq}, 0);
        wr(9, 32'h200);
        chk("R8 irq high on second event", {31'h0, irq}, 1);
        wr(10, 32'h3FF);
        rd(8, 32'h3FF, "R7 disable sets bits");
        chk("R8 irq low after masking", {31'h0, irq}, 0);
        wr(4, 32'h3FF);

        // R10 transfer size
        wr(5, 32'h1FF);
        rd(5, 32'hFF, "R10 low eight bits kept");
        eng_dec(); eng_dec(); eng_dec();
        rd(5, 32'hFC, "R10 live decrement");
        wr(5, 32'h2);
        eng_dec(); eng_dec(); eng_dec();
        rd(5, 32'h0, "R10 floor at zero");

        // R11 bus active
        eng_busy = 1;
        rd(1, 32'h100, "R11 bus active bit");
        eng_busy = 0;
        rd(1, 32'h0, "R11 bus idle");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule